// File: doc/BRIEF.md
# Sequential Shift-Subtract Narrowing Divider

This block divides a 32-bit unsigned dividend by a 16-bit unsigned divisor and returns a 16-bit quotient and a 16-bit remainder. It is a radix-2 restoring divider. The dividend sits in a pair of 16-bit registers, and each clock cycle performs one trial subtraction and one left shift. After sixteen steps the low register holds the quotient and the high register holds the remainder. The divisor is captured once and does not change during the operation.

A request is a single-cycle `start` with the operands on `dividend` and `divisor`. The block accepts it only while `busy` is low. `busy` therefore serves as the inverse of a ready signal. A `start` that arrives while `busy` is high is dropped, and its operands are never captured. There is no back-pressure on the result side. `done` pulses for one cycle, and the outputs then stay unchanged until the next result replaces them.

If the upper half of the dividend is greater than or equal to the divisor, the quotient would not fit in 16 bits. The block flags this case and does not compute it. A zero divisor is flagged separately. A valid remainder is always smaller than the divisor, so it can be placed in the upper half of the next dividend. Doing this once per 16-bit word divides a number of any width by a 16-bit divisor.

Top module: `narrow_div`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy`, `done`, `overflow` and `div_zero` are 0, and `quotient` and `remainder` are 0.
- R2: A `start` sampled while `busy` is low is accepted, and `busy` is high in the following cycle. A `start` sampled while `busy` is high is ignored and does not change the pending result.
- R3: `done` is high for exactly one cycle, 17 clock edges after the accepting edge. `busy` stays high from the accepting edge until the edge that raises `done`, and never overlaps `done`.
- R4: When the divisor is nonzero and `dividend[31:16]` is less than the divisor, `quotient` equals the dividend divided by the divisor and `remainder` equals the dividend modulo the divisor, both unsigned.
- R5: When the divisor is nonzero and `dividend[31:16]` is greater than or equal to the divisor, `overflow` is 1, `div_zero` is 0, and `quotient` and `remainder` are both 16'hFFFF.
- R6: When the divisor is zero, `div_zero` is 1, `overflow` is 0, and `quotient` and `remainder` are both 16'hFFFF.
- R7: `quotient`, `remainder`, `overflow` and `div_zero` change only on the edge that raises `done`, and hold their values otherwise.
- R8: A valid result has `remainder` less than the divisor. When that remainder is used as `dividend[31:16]` for the next 16-bit word, the chain of quotient words gives the quotient and remainder of the wider division.
- R9: A valid result clears both `overflow` and `div_zero`, even if the previous result had set them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only while busy is low |
| dividend | input | 32 | Unsigned dividend |
| divisor | input | 16 | Unsigned divisor |
| busy | output | 1 | Operation in progress; new requests are dropped |
| done | output | 1 | One-cycle result strobe |
| quotient | output | 16 | Quotient, or all ones when flagged |
| remainder | output | 16 | Remainder, or all ones when flagged |
| overflow | output | 1 | Quotient does not fit in 16 bits |
| div_zero | output | 1 | Divisor was zero |

## Verification
The hardest case to reach from the ports is a `start` that arrives mid-operation. The drop happens silently, so a wrong capture only shows up later as a corrupted result. The stimulus raises `start` with different operands partway through a run and then checks that the original quotient still comes out. The remainder-chaining path is also hard to reach. It is driven by dividing a 48-bit value word by word, feeding each remainder back as the upper half, and comparing the assembled quotient with a whole-number division. The table also covers the overflow boundary, where the upper half equals the divisor, and a flagged result followed directly by a valid one, which shows the flags clearing.

// File: rtl/nd_pkg.sv
package nd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } nd_state_e;

  typedef struct packed {
    logic dz;
    logic ovf;
  } nd_flags_t;
endpackage

// File: rtl/nd_step.sv
// One restoring step: trial-subtract the divisor from the top W+1 bits
// of the partial remainder pair, then shift the pair left by one.
module nd_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] hi_nx,
  output logic [W-1:0] lo_nx,
  output logic         spill
);
  logic [W:0]   cand;
  logic [W+1:0] sub;
  logic         borrow;

  always_comb begin
    cand   = {hi, lo[W-1]};
    sub    = {1'b0, cand} - {2'b00, dvs};
    borrow = sub[W+1];
    hi_nx  = borrow ? cand[W-1:0] : sub[W-1:0];
    lo_nx  = {lo[W-2:0], ~borrow};
    // A kept difference wider than W bits means the hi<dvs invariant broke.
    spill  = ~borrow & sub[W];
  end
endmodule

// File: rtl/nd_ctrl.sv
module nd_ctrl
  import nd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic load,
  output logic iterate,
  output logic finish
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  nd_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    iterate = 1'b0;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          cnt_d   = '0;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        iterate = 1'b1;
        cnt_d   = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_FIN;
      end
      ST_FIN: begin
        finish  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy = (state_q != ST_IDLE);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  assert_run_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_FIN) |-> $past(cnt_q) == LAST && $past(state_q) == ST_RUN);

  assert_fin_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy);
endmodule

// File: rtl/nd_result.sv
module nd_result
  import nd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         finish,
  input  nd_flags_t    flags,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         overflow,
  output logic         div_zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      overflow  <= 1'b0;
      div_zero  <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        div_zero <= flags.dz;
        overflow <= flags.ovf & ~flags.dz;
        if (flags.dz || flags.ovf) begin
          quotient  <= '1;
          remainder <= '1;
        end else begin
          quotient  <= lo;
          remainder <= hi;
        end
      end
    end
  end

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(quotient) && $stable(remainder) && $stable(overflow) && $stable(div_zero));

  assert_dz_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && div_zero |-> quotient == '1 && remainder == '1 && !overflow);

  assert_ovf_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && overflow |-> quotient == '1 && remainder == '1 && !div_zero);
endmodule

// File: rtl/narrow_div.sv
module narrow_div
  import nd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder,
  output logic           overflow,
  output logic           div_zero
);
  localparam int DW = 2 * W;

  logic         load, iterate, finish, spill;
  logic [W-1:0] hi_q, lo_q, dvs_q, hi_nx, lo_nx;
  nd_flags_t    flags_q;
  logic         skip;

  nd_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .load    (load),
    .iterate (iterate),
    .finish  (finish)
  );

  nd_step #(.W(W)) u_step (
    .hi    (hi_q),
    .lo    (lo_q),
    .dvs   (dvs_q),
    .hi_nx (hi_nx),
    .lo_nx (lo_nx),
    .spill (spill)
  );

  assign skip = flags_q.dz | flags_q.ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      dvs_q   <= '0;
      flags_q <= '0;
    end else if (load) begin
      hi_q        <= dividend[DW-1:W];
      lo_q        <= dividend[W-1:0];
      dvs_q       <= divisor;
      flags_q.dz  <= (divisor == '0);
      flags_q.ovf <= (divisor != '0) && (dividend[DW-1:W] >= divisor);
    end else if (iterate && !skip) begin
      hi_q <= hi_nx;
      lo_q <= lo_nx;
    end
  end

  nd_result #(.W(W)) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .finish    (finish),
    .flags     (flags_q),
    .hi        (hi_q),
    .lo        (lo_q),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .overflow  (overflow),
    .div_zero  (div_zero)
  );

  assert_partial_below_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !skip |-> hi_q < dvs_q && !spill);

  assert_rem_below_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !overflow && !div_zero |-> remainder < dvs_q);

  assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow && div_zero));

  assert_no_busy_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

// File: tb/tb_narrow_div.sv
`timescale 1ns/1ps
module tb_narrow_div;
  localparam int W = 16;
  localparam int NV = 14;
  localparam logic [47:0] VEC [NV] = '{
    {32'h0000_0000, 16'h0001},
    {32'h0000_FFFF, 16'h0001},
    {32'hFFFE_FFFF, 16'hFFFF},
    {32'h1234_5678, 16'h8000},
    {32'h0000_0064, 16'h000A},
    {32'h0000_0003, 16'h0007},
    {32'h7FFF_FFFF, 16'h8000},
    {32'h0001_0000, 16'h0001},
    {32'h8000_0000, 16'h8000},
    {32'hFFFF_FFFF, 16'h0000},
    {32'h0000_0000, 16'h0000},
    {32'h0000_1234, 16'h0003},
    {32'h00FF_0000, 16'h00FF},
    {32'h00FE_FFFF, 16'h00FF}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic busy, done, overflow, div_zero;
  logic [15:0] quotient, remainder;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  narrow_div #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .overflow(overflow), .div_zero(div_zero)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one division; optionally fires a start with junk operands mid-run.
  task automatic run_div(input logic [31:0] a, input logic [15:0] b, input bit inject,
                         output logic [15:0] q_o, output logic [15:0] r_o);
    logic [15:0] eq, er;
    bit eo, ez, tbad;
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; dividend = ~a; divisor = ~b;
    chk(busy === 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
    tbad = 0;
    for (int k = 0; k < 16; k++) begin
      if (inject && k == 5) start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (busy !== 1'b1 || done !== 1'b0) tbad = 1;
    end
    chk(!tbad, "R3 busy held, no early done", 64'({busy, done}), 64'b10);
    @(posedge clk);
    @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, "R3 done at edge 17", 64'({done, busy}), 64'b10);
    ez = (b == 0);
    eo = !ez && (a[31:16] >= b);
    if (ez || eo) begin eq = '1; er = '1; end
    else begin eq = 16'(a / 32'(b)); er = 16'(a % 32'(b)); end
    chk(quotient === eq && remainder === er,
        ez ? "R6 dz outputs" : eo ? "R5 ovf outputs" : (inject ? "R2 ignored start" : "R4 quotient/remainder"),
        64'({quotient, remainder}), 64'({eq, er}));
    chk(overflow === eo && div_zero === ez, (ez || eo) ? "R5 R6 flags" : "R9 flags clear",
        64'({overflow, div_zero}), 64'({eo, ez}));
    q_o = quotient; r_o = remainder;
    @(posedge clk);
    @(negedge clk);
    chk(done === 1'b0 && quotient === eq && remainder === er, "R7 hold after done",
        64'({done, quotient, remainder}), 64'({1'b0, eq, er}));
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] q, r, q1, q2, q3, dv;
    logic [47:0] big;
    repeat (3) @(negedge clk);
    chk({busy, done, overflow, div_zero, quotient, remainder} === '0, "R1 reset state",
        64'({busy, done, overflow, div_zero, quotient, remainder}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, overflow, div_zero, quotient, remainder} === '0, "R1 after release",
        64'({busy, done, overflow, div_zero, quotient, remainder}), 64'd0);

    for (int i = 0; i < NV; i++) run_div(VEC[i][47:16], VEC[i][15:0], 1'b0, q, r);

    // R2: start during busy must be dropped
    run_div(32'h0042_1357, 16'h00A3, 1'b1, q, r);
    // R9: flagged result followed by a valid one
    run_div(32'hFFFF_0000, 16'h0010, 1'b0, q, r);
    run_div(32'h000F_0000, 16'h0010, 1'b0, q, r);

    for (int i = 0; i < 40; i++) begin
      logic [15:0] d;
      logic [31:0] n;
      d = 16'($urandom());
      n = $urandom();
      if (i % 4 != 0 && d != 0) n[31:16] = n[31:16] % d;
      run_div(n, d, 1'b0, q, r);
    end

    // R8: 48-bit / 16-bit by chaining remainders
    for (int t = 0; t < 4; t++) begin
      big = {16'($urandom()), 32'($urandom())};
      dv  = 16'($urandom()) | 16'h0001;
      run_div({16'h0000, big[47:32]}, dv, 1'b0, q1, r);
      run_div({r, big[31:16]}, dv, 1'b0, q2, r);
      run_div({r, big[15:0]}, dv, 1'b0, q3, r);
      chk({q1, q2, q3} === big / 48'(dv) && r === 16'(big % 48'(dv)), "R8 chained division",
          64'({q1, q2, q3}), 64'(big / 48'(dv)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule